// File: doc/BRIEF.md
# Data Space Address Generator

This block forms the effective data address for each load or store of a small 8-bit processor core and steers the access to one of three regions in a flat map. The three regions are the general-purpose register file, the I/O register space and the internal SRAM. The address comes either straight from the instruction (direct) or from one of three 16-bit pointer pairs. A pointer can be used as it stands, with an unsigned 6-bit displacement added, decremented before use, or incremented after use. For the last two modes the block returns the updated pointer, together with a write enable and the index of the pair's low register, so that the register file can store it in the same cycle.

The core raises `req_i` with the mode, the pointer choice, the displacement, the direct address and the current value of the chosen pair. One clock later the block presents its registered result. That result holds the effective address, a one-hot region select, the offset within that region, flags for an address beyond the map or an illegal request, and the pointer write-back. The register storage, the peripherals and the SRAM lie outside this block.

Top module: `dspace_agen`

## Requirements
- R1: Every output is registered, so the result of a request sampled at a rising edge appears after that edge and lasts one cycle. During reset, and in the cycle after any edge where `req_i` was low, all outputs are zero.
- R2: The map holds 224 locations. Addresses 0x00–0x1F assert `sel_o[0]` (registers) with `offset_o` equal to the address.
- R3: Addresses 0x20–0x5F assert `sel_o[1]` (I/O) with `offset_o` equal to the address minus 0x20.
- R4: Addresses 0x60–0xDF assert `sel_o[2]` (SRAM) with `offset_o` equal to the address minus 0x60. At most one select bit is ever high, and `acc_vld_o` is high exactly when one is.
- R5: Mode 0 (direct) uses `dir_addr_i` as the effective address, which can reach any location from 0x00 to 0xDF. It writes back no pointer.
- R6: Mode 1 (indirect) uses the selected pointer unchanged as the address and writes back no pointer. Pointer codes are 0 = X, 1 = Y, 2 = Z.
- R7: Mode 2 (displacement) with Y or Z uses the pointer plus the zero-extended `disp_i` (0 to 63), modulo 2^16. It writes back no pointer.
- R8: Mode 3 (pre-decrement) uses the pointer minus one as the address and writes back that same value. The value wraps from 0x0000 to 0xFFFF.
- R9: Mode 4 (post-increment) uses the unchanged pointer as the address and writes back the pointer plus one. The value wraps from 0xFFFF to 0x0000.
- R10: `wb_en_o` is high only in the result cycle of a legal mode 3 or mode 4 request. `wb_reg_o` is then 26, 28 or 30 for X, Y or Z.
- R11: An effective address above 0xDF gives no select, `acc_vld_o` low, `offset_o` zero and `oor_o` high for one cycle. The pointer write-back of modes 3 and 4 still happens.
- R12: A request is illegal if it is mode 2 with X, uses pointer code 3 in modes 1 to 4, or uses a mode code from 5 to 7. An illegal request raises `err_o` for one cycle, and every other output stays zero (no access, no select, no out-of-range flag, no write-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| mode_i | input | 3 | Addressing mode code (0 to 4 legal) |
| psel_i | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp_i | input | 6 | Unsigned displacement for mode 2 |
| dir_addr_i | input | 16 | Address taken from the instruction for mode 0 |
| ptr_val_i | input | 16 | Current value of the selected pointer pair (read port) |
| acc_vld_o | output | 1 | A legal access to a mapped location |
| ea_o | output | 16 | Effective address |
| sel_o | output | 3 | One-hot region select: bit 0 registers, bit 1 I/O, bit 2 SRAM |
| offset_o | output | 7 | Offset within the selected region |
| oor_o | output | 1 | Effective address lies beyond the map |
| err_o | output | 1 | Illegal request |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_reg_o | output | 5 | Register number of the low byte of the pair being written |
| wb_val_o | output | 16 | New pointer value |

## Verification
The corner cases that are hardest to reach are the pointer updates that wrap at the 16-bit boundary and also land outside the map. These require a pre-decrement from 0x0000 or a post-increment that walks off 0xDF, and in both cases the write-back must still happen while every region select stays low. The bench holds its own copy of the three pointer pairs. It sets them to the values just below and above the region borders and at the 16-bit ends, and chains post-increments on the same pair so that the updated value is fed back as the next pointer. Illegal combinations are placed between legal requests, which shows that they leave no trace in the next result.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_DISP    = 3'd2,
      AM_PREDEC  = 3'd3,
      AM_POSTINC = 3'd4
   } amode_e;

   typedef enum logic [1:0] {
      PS_X   = 2'd0,
      PS_Y   = 2'd1,
      PS_Z   = 2'd2,
      PS_BAD = 2'd3
   } psel_e;

   localparam int NUM_REGIONS = 3;

endpackage

// File: rtl/dsa_ptr_unit.sv
module dsa_ptr_unit
   import dsa_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DISP_W   = 6,
   parameter int RIDX_W   = 5,
   parameter int PTR_BASE = 26
) (
   input  logic [2:0]        mode_i,
   input  logic [1:0]        psel_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [AW-1:0]     dir_addr_i,
   input  logic [AW-1:0]     ptr_val_i,
   output logic [AW-1:0]     ea_o,
   output logic              illegal_o,
   output logic              wb_en_o,
   output logic [RIDX_W-1:0] wb_reg_o,
   output logic [AW-1:0]     wb_val_o
);

   logic [AW-1:0] ptr_dec;
   logic [AW-1:0] ptr_inc;
   logic [AW-1:0] ptr_off;
   logic          bad_ptr;
   logic          want_wb;

   assign ptr_dec = ptr_val_i - AW'(1);
   assign ptr_inc = ptr_val_i + AW'(1);
   assign ptr_off = ptr_val_i + AW'(disp_i);
   assign bad_ptr = (psel_i == PS_BAD);

   // pair index: low byte of X, Y, Z at base, base+2, base+4
   assign wb_reg_o = RIDX_W'(PTR_BASE) + RIDX_W'({psel_i, 1'b0});

   always_comb begin
      ea_o      = dir_addr_i;
      illegal_o = 1'b0;
      want_wb   = 1'b0;
      wb_val_o  = ptr_val_i;
      case (mode_i)
         AM_DIRECT: begin
            ea_o = dir_addr_i;
         end
         AM_IND: begin
            ea_o      = ptr_val_i;
            illegal_o = bad_ptr;
         end
         AM_DISP: begin
            ea_o      = ptr_off;
            illegal_o = bad_ptr || (psel_i == PS_X);
         end
         AM_PREDEC: begin
            ea_o      = ptr_dec;
            wb_val_o  = ptr_dec;
            want_wb   = 1'b1;
            illegal_o = bad_ptr;
         end
         AM_POSTINC: begin
            ea_o      = ptr_val_i;
            wb_val_o  = ptr_inc;
            want_wb   = 1'b1;
            illegal_o = bad_ptr;
         end
         default: begin
            illegal_o = 1'b1;
         end
      endcase
   end

   assign wb_en_o = want_wb && !illegal_o;

endmodule

// File: rtl/dsa_region_dec.sv
module dsa_region_dec
   import dsa_pkg::*;
#(
   parameter int AW    = 16,
   parameter int N_GPR = 32,
   parameter int N_IO  = 64,
   parameter int N_RAM = 128,
   parameter int OFF_W = 7
) (
   input  logic [AW-1:0]          ea_i,
   output logic [NUM_REGIONS-1:0] hit_o,
   output logic [OFF_W-1:0]       offset_o,
   output logic                   in_map_o
);

   function automatic int rsize(input int r);
      case (r)
         0:       return N_GPR;
         1:       return N_IO;
         default: return N_RAM;
      endcase
   endfunction

   function automatic int rbase(input int r);
      int b;
      b = 0;
      for (int i = 0; i < r; i++) b = b + rsize(i);
      return b;
   endfunction

   logic [OFF_W-1:0] offs [NUM_REGIONS];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      localparam int LO = rbase(r);
      localparam int HI = LO + rsize(r);
      assign hit_o[r] = (ea_i >= AW'(LO)) && (ea_i < AW'(HI));
      assign offs[r]  = OFF_W'(ea_i - AW'(LO));
   end

   always_comb begin
      offset_o = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (hit_o[r]) offset_o = offset_o | offs[r];
      end
   end

   assign in_map_o = |hit_o;

endmodule

// File: rtl/dspace_agen.sv
module dspace_agen
   import dsa_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DISP_W   = 6,
   parameter int RIDX_W   = 5,
   parameter int PTR_BASE = 26,
   parameter int N_GPR    = 32,
   parameter int N_IO     = 64,
   parameter int N_RAM    = 128,
   localparam int MAX_N   = (N_RAM > N_IO) ? ((N_RAM > N_GPR) ? N_RAM : N_GPR)
                                           : ((N_IO > N_GPR) ? N_IO : N_GPR),
   localparam int OFF_W   = $clog2(MAX_N)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_i,
   input  logic [2:0]             mode_i,
   input  logic [1:0]             psel_i,
   input  logic [DISP_W-1:0]      disp_i,
   input  logic [AW-1:0]          dir_addr_i,
   input  logic [AW-1:0]          ptr_val_i,
   output logic                   acc_vld_o,
   output logic [AW-1:0]          ea_o,
   output logic [NUM_REGIONS-1:0] sel_o,
   output logic [OFF_W-1:0]       offset_o,
   output logic                   oor_o,
   output logic                   err_o,
   output logic                   wb_en_o,
   output logic [RIDX_W-1:0]      wb_reg_o,
   output logic [AW-1:0]          wb_val_o
);

   // elaboration-time parameter checks
   if (AW < 8) begin : g_bad_aw
      $error("dspace_agen: AW must be at least 8");
   end
   if (N_GPR + N_IO + N_RAM > 2 ** AW) begin : g_bad_map
      $error("dspace_agen: regions exceed the address width");
   end
   if (PTR_BASE + 5 >= 2 ** RIDX_W) begin : g_bad_ridx
      $error("dspace_agen: pointer registers exceed the register index width");
   end

   logic [AW-1:0]          ea_c;
   logic                   illegal_c;
   logic                   wb_en_c;
   logic [RIDX_W-1:0]      wb_reg_c;
   logic [AW-1:0]          wb_val_c;
   logic [NUM_REGIONS-1:0] hit_c;
   logic [OFF_W-1:0]       off_c;
   logic                   in_map_c;

   dsa_ptr_unit #(
      .AW(AW), .DISP_W(DISP_W), .RIDX_W(RIDX_W), .PTR_BASE(PTR_BASE)
   ) u_ptr (
      .mode_i     (mode_i),
      .psel_i     (psel_i),
      .disp_i     (disp_i),
      .dir_addr_i (dir_addr_i),
      .ptr_val_i  (ptr_val_i),
      .ea_o       (ea_c),
      .illegal_o  (illegal_c),
      .wb_en_o    (wb_en_c),
      .wb_reg_o   (wb_reg_c),
      .wb_val_o   (wb_val_c)
   );

   dsa_region_dec #(
      .AW(AW), .N_GPR(N_GPR), .N_IO(N_IO), .N_RAM(N_RAM), .OFF_W(OFF_W)
   ) u_dec (
      .ea_i     (ea_c),
      .hit_o    (hit_c),
      .offset_o (off_c),
      .in_map_o (in_map_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_vld_o <= 1'b0;
         ea_o      <= '0;
         sel_o     <= '0;
         offset_o  <= '0;
         oor_o     <= 1'b0;
         err_o     <= 1'b0;
         wb_en_o   <= 1'b0;
         wb_reg_o  <= '0;
         wb_val_o  <= '0;
      end else if (req_i && !illegal_c) begin
         acc_vld_o <= in_map_c;
         ea_o      <= ea_c;
         sel_o     <= hit_c;
         offset_o  <= in_map_c ? off_c : '0;
         oor_o     <= !in_map_c;
         err_o     <= 1'b0;
         wb_en_o   <= wb_en_c;
         wb_reg_o  <= wb_en_c ? wb_reg_c : '0;
         wb_val_o  <= wb_en_c ? wb_val_c : '0;
      end else begin
         acc_vld_o <= 1'b0;
         ea_o      <= '0;
         sel_o     <= '0;
         offset_o  <= '0;
         oor_o     <= 1'b0;
         err_o     <= req_i;
         wb_en_o   <= 1'b0;
         wb_reg_o  <= '0;
         wb_val_o  <= '0;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!acc_vld_o && !err_o && !oor_o && !wb_en_o && sel_o == '0));

   // R4
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o) && (acc_vld_o == (sel_o != '0)));

   // R3
   io_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[1] |-> (AW'(offset_o) == ea_o - AW'(N_GPR)));

   // R11
   oor_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oor_o |-> (sel_o == '0 && !acc_vld_o && !err_o));

   // R12
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!acc_vld_o && !wb_en_o && !oor_o && sel_o == '0));

   // R10
   wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> $past(req_i && (mode_i == AM_PREDEC || mode_i == AM_POSTINC)));

   // R8
   wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (wb_val_o == ea_o || wb_val_o == ea_o + AW'(1)));

endmodule

// File: tb/dspace_agen_test.sv
`timescale 1ns/1ps
module dspace_agen_test;

   typedef struct packed {
      logic        acc;
      logic [15:0] ea;
      logic [2:0]  sel;
      logic [6:0]  off;
      logic        oor;
      logic        err;
      logic        wb_en;
      logic [4:0]  wb_reg;
      logic [15:0] wb_val;
   } res_t;

   typedef struct {
      res_t  r;
      string tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [1:0]  psel_i = '0;
   logic [5:0]  disp_i = '0;
   logic [15:0] dir_addr_i = '0;
   logic [15:0] ptr_val_i = '0;
   logic        acc_vld_o, oor_o, err_o, wb_en_o;
   logic [15:0] ea_o, wb_val_o;
   logic [2:0]  sel_o;
   logic [6:0]  offset_o;
   logic [4:0]  wb_reg_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [15:0] preg [3];
   item_t exp_q [$];

   always #5 clk = ~clk;

   dspace_agen uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
      .psel_i(psel_i), .disp_i(disp_i), .dir_addr_i(dir_addr_i),
      .ptr_val_i(ptr_val_i), .acc_vld_o(acc_vld_o), .ea_o(ea_o),
      .sel_o(sel_o), .offset_o(offset_o), .oor_o(oor_o), .err_o(err_o),
      .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_val_o(wb_val_o)
   );

   function automatic res_t actual();
      res_t a;
      a = '{acc_vld_o, ea_o, sel_o, offset_o, oor_o, err_o,
            wb_en_o, wb_reg_o, wb_val_o};
      return a;
   endfunction

   function automatic res_t model(input logic [2:0] m, input logic [1:0] p,
                                  input logic [5:0] d, input logic [15:0] da,
                                  input logic [15:0] pv);
      res_t e;
      logic [15:0] a;
      bit bad, wb;
      e = '0;
      bad = (m > 3'd4) || (m != 3'd0 && p == 2'd3) || (m == 3'd2 && p == 2'd0);
      if (bad) begin
         e.err = 1'b1;
         return e;
      end
      wb = 1'b0;
      case (m)
         3'd0: a = da;
         3'd1: a = pv;
         3'd2: a = pv + {10'd0, d};
         3'd3: begin a = pv - 16'd1; wb = 1'b1; e.wb_val = a; end
         default: begin a = pv; wb = 1'b1; e.wb_val = pv + 16'd1; end
      endcase
      e.ea = a;
      if (wb) begin
         e.wb_en  = 1'b1;
         e.wb_reg = 5'd26 + 5'(2 * p);
      end
      if (a < 16'h20) begin
         e.sel = 3'b001; e.off = a[6:0]; e.acc = 1'b1;
      end else if (a < 16'h60) begin
         e.sel = 3'b010; e.off = 7'(a - 16'h20); e.acc = 1'b1;
      end else if (a < 16'hE0) begin
         e.sel = 3'b100; e.off = 7'(a - 16'h60); e.acc = 1'b1;
      end else begin
         e.oor = 1'b1;
      end
      return e;
   endfunction

   task automatic drive(input logic [2:0] m, input logic [1:0] p,
                        input logic [5:0] d, input logic [15:0] da,
                        input string tag);
      item_t it;
      logic [15:0] pv;
      @(negedge clk);
      pv = (p == 2'd3) ? 16'h0000 : preg[p];
      req_i = 1'b1; mode_i = m; psel_i = p; disp_i = d;
      dir_addr_i = da; ptr_val_i = pv;
      it.r = model(m, p, d, da, pv);
      it.tag = tag;
      exp_q.push_back(it);
      if (it.r.wb_en) preg[p] = it.r.wb_val;
   endtask

   task automatic idle(input string tag);
      item_t it;
      @(negedge clk);
      req_i = 1'b0;
      mode_i = 3'd4; psel_i = 2'd1; ptr_val_i = 16'h0030;
      it.r = '0;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: pops one expected item per result cycle
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         item_t it;
         res_t a;
         it = exp_q.pop_front();
         a = actual();
         checks++;
         if (a !== it.r) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, a, it.r);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      preg[0] = 16'h0010; preg[1] = 16'h0050; preg[2] = 16'h00A0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (actual() !== '0) begin   // R1 reset state
         fails++;
         $display("FAIL R1 reset: actual %h expected %h", actual(), res_t'('0));
      end
      @(negedge clk);
      rst_n = 1'b1;

      // direct mode across region borders
      drive(3'd0, 2'd0, 6'd0, 16'h0000, "R2 direct 0x00");
      drive(3'd0, 2'd0, 6'd0, 16'h001F, "R2 direct 0x1F");
      drive(3'd0, 2'd0, 6'd0, 16'h0020, "R3 direct 0x20");
      drive(3'd0, 2'd0, 6'd0, 16'h005F, "R3 direct 0x5F");
      drive(3'd0, 2'd0, 6'd0, 16'h0060, "R4 direct 0x60");
      drive(3'd0, 2'd0, 6'd0, 16'h00DF, "R5 direct 0xDF");
      drive(3'd0, 2'd0, 6'd0, 16'h00E0, "R11 direct 0xE0");
      drive(3'd0, 2'd0, 6'd0, 16'h1234, "R11 direct 0x1234");
      idle("R1 idle after burst");

      // indirect
      drive(3'd1, 2'd0, 6'd5, 16'h0000, "R6 indirect X");
      drive(3'd1, 2'd1, 6'd0, 16'h0000, "R6 indirect Y");
      drive(3'd1, 2'd2, 6'd0, 16'h0000, "R6 indirect Z");

      // displacement
      drive(3'd2, 2'd1, 6'd63, 16'h0000, "R7 disp Y+63");
      drive(3'd2, 2'd2, 6'd0, 16'h0000, "R7 disp Z+0");
      preg[2] = 16'hFFF0;
      drive(3'd2, 2'd2, 6'd32, 16'h0000, "R7 disp Z wrap");

      // illegal requests between legal ones
      drive(3'd2, 2'd0, 6'd1, 16'h0000, "R12 disp with X");
      drive(3'd1, 2'd3, 6'd0, 16'h0000, "R12 pointer code 3");
      drive(3'd6, 2'd1, 6'd0, 16'h0000, "R12 mode code 6");
      drive(3'd0, 2'd0, 6'd0, 16'h0040, "R12 legal after illegal");

      // pre-decrement and post-increment
      preg[0] = 16'h0021;
      drive(3'd3, 2'd0, 6'd0, 16'h0000, "R8 predec X");
      drive(3'd3, 2'd0, 6'd0, 16'h0000, "R8 predec X again");
      preg[1] = 16'h0000;
      drive(3'd3, 2'd1, 6'd0, 16'h0000, "R11 predec Y wrap");
      preg[2] = 16'h00DF;
      drive(3'd4, 2'd2, 6'd0, 16'h0000, "R9 postinc Z 0xDF");
      drive(3'd4, 2'd2, 6'd0, 16'h0000, "R10 postinc Z off map");
      preg[1] = 16'hFFFF;
      drive(3'd4, 2'd1, 6'd0, 16'h0000, "R9 postinc Y wrap");
      drive(3'd1, 2'd1, 6'd0, 16'h0000, "R10 indirect Y after wrap");
      drive(3'd4, 2'd3, 6'd0, 16'h0000, "R12 postinc bad pointer");
      idle("R1 idle at end");
      idle("R1 idle twice");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule